// File: doc/BRIEF.md
# Pipelined Bus Memory Slave

This block is a slave on a pipelined, AHB-style system bus. It fronts a small internal memory organised as words. In every address phase it looks at the transfer type, the address, the direction and the size. One cycle later, or more if wait states are configured, it carries out the matching read or write in the data phase. The next address phase overlaps the current data phase, so a master can issue transfers back to back with no dead cycles.

Accesses that fall outside the memory, or that are not aligned to their size, are refused with a two-cycle error response, and the memory is left unchanged. Idle and busy cycles are answered at once with no memory activity. A parameter sets the number of wait states added to every data phase.

Top module: `bmem_slave`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busReady` is 1 and `busResp` is 00 (OKAY). Reset is active low and asynchronous.
- R2: A cycle in which `busReady` is 1 and `busTrans` is 00 (idle) or 01 (busy) is followed by a data phase with `busReady` 1 and `busResp` 00. That cycle reads and writes no memory word.
- R3: Transfer types 10 (non-sequential) and 11 (sequential) are accepted in any cycle where `busReady` is 1. With no wait states, consecutive accepted transfers complete in consecutive cycles.
- R4: In the final data-phase cycle (`busReady` 1), a write stores `busWdata` and a read presents the addressed word on `busRdata`. A read issued directly after a write to the same word returns the new data.
- R5: `busSize` 0 is a byte, 1 is a halfword and 2 is a word. A write updates only the byte lanes that hold the addressed unit, where lane n is bits 8n+7..8n and is selected by the low address bits. A read always returns the full word.
- R6: An access at a byte address of DEPTH*4 or higher gets `busReady` 0 with `busResp` 01 (ERROR), followed by `busReady` 1 with `busResp` 01. This holds whatever the wait-state setting.
- R7: An access whose address is not a multiple of its size, or whose `busSize` is above 2, gets the same two-cycle error, and memory is not written.
- R8: With WAIT_STATES = N, an accepted valid access holds `busReady` at 0 for the first N cycles of its data phase and completes in cycle N+1.
- R9: `busResp` only ever takes the values 00 or 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every sample is taken on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busTrans | input | 2 | Transfer type: 00 idle, 01 busy, 10 non-sequential, 11 sequential |
| busAddr | input | ADDR_W | Byte address of the address phase |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busSize | input | 3 | log2 of the transfer size in bytes |
| busWdata | input | DATA_W | Write data, valid in the data phase |
| busRdata | output | DATA_W | Read data, valid when `busReady` is 1 |
| busReady | output | 1 | Low to stretch the current data phase |
| busResp | output | 2 | 00 OKAY or 01 ERROR |

## Verification
If the phase register or the wait counter holds a wrong value, `busReady` or `busResp` shows it in the very next cycle. Examples are an extra or missing low cycle, a one-cycle error instead of two, and an error on an idle cycle. The bench samples both outputs in every cycle of each sequence. A wrong captured index or lane mask does not show until a later read of the word concerned. For that reason every write scenario ends with a pipelined read-back, and each refused or idle access is followed by a read of the word it pointed at.

// File: rtl/bmem_pkg.sv
package bmem_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    RS_OKAY  = 2'b00,
    RS_ERROR = 2'b01,
    RS_RETRY = 2'b10,
    RS_SPLIT = 2'b11
  } resp_e;

  // what the slave is doing in the current data phase
  typedef enum logic [1:0] {
    PH_NONE,
    PH_ACCESS,
    PH_ERR1,
    PH_ERR2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch address-phase fields this edge
    logic beatDone;  // data phase of a valid access completes this edge
  } strobe_t;

endpackage

// File: rtl/bmem_ctrl.sv
module bmem_ctrl
  import bmem_pkg::*;
#(
  parameter int WAIT_STATES = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busTrans,
  input  logic       addrBad,
  output logic       busReady,
  output logic [1:0] busResp,
  output strobe_t    stb
);

  localparam int CNT_W = $clog2(WAIT_STATES + 2);
  localparam logic [CNT_W-1:0] WAIT_T = CNT_W'(WAIT_STATES);

  phase_e           phase;
  logic [CNT_W-1:0] waitCnt;
  logic             active;

  assign active = (busTrans == TR_NONSEQ) || (busTrans == TR_SEQ);

  always_comb begin
    unique case (phase)
      PH_ACCESS: busReady = (waitCnt == WAIT_T);
      PH_ERR1:   busReady = 1'b0;
      default:   busReady = 1'b1;
    endcase
    busResp = ((phase == PH_ERR1) || (phase == PH_ERR2)) ? RS_ERROR : RS_OKAY;
    stb.capture  = busReady && active && !addrBad;
    stb.beatDone = (phase == PH_ACCESS) && busReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_NONE;
      waitCnt <= '0;
    end else if (busReady) begin
      waitCnt <= '0;
      if (active) phase <= addrBad ? PH_ERR1 : PH_ACCESS;
      else        phase <= PH_NONE;
    end else if (phase == PH_ERR1) begin
      phase <= PH_ERR2;
    end else if (phase == PH_ACCESS) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  // R2: idle/busy gets a zero-wait OKAY
  p_idle_okay_r2: assert property (@(posedge clk) disable iff (!rstN)
    busReady && !active |=> busReady && (busResp == RS_OKAY));

  // R6: refused access enters the first error cycle
  p_err_enter_r6: assert property (@(posedge clk) disable iff (!rstN)
    busReady && active && addrBad |=> !busReady && (busResp == RS_ERROR));

  // R6: first error cycle is always followed by the second
  p_err_second_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busReady && (busResp == RS_ERROR) |=> busReady && (busResp == RS_ERROR));

  // R8: valid access with wait states starts stretched
  p_wait_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (WAIT_STATES > 0) && busReady && active && !addrBad |=> !busReady);

  // R8: counter never passes its limit
  p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= WAIT_T);

  // R9: only OKAY or ERROR
  p_resp_legal_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busResp[1]);

endmodule

// File: rtl/bmem_datapath.sv
module bmem_datapath
  import bmem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [2:0]        busSize,
  input  logic [DATA_W-1:0] busWdata,
  output logic              addrBad,
  output logic [DATA_W-1:0] busRdata
);

  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);
  localparam int IDX_W = $clog2(DEPTH);

  logic [ADDR_W-1:0] wordNum;
  logic [OFF_W-1:0]  offset;
  logic              misaligned, sizeTooBig, outOfRange;
  logic [BYTES-1:0]  lanes;

  logic [IDX_W-1:0]  idxReg;
  logic              wrReg;
  logic [BYTES-1:0]  lanesReg;
  logic [DATA_W-1:0] mem [DEPTH];

  assign wordNum = busAddr >> OFF_W;
  assign offset  = busAddr[OFF_W-1:0];

  always_comb begin
    sizeTooBig = int'(busSize) > OFF_W;
    outOfRange = wordNum >= ADDR_W'(DEPTH);
    misaligned = 1'b0;
    for (int k = 0; k < OFF_W; k++)
      if ((k < int'(busSize)) && offset[k]) misaligned = 1'b1;
    for (int b = 0; b < BYTES; b++)
      lanes[b] = ((b >> busSize) == (int'(offset) >> busSize));
    addrBad = sizeTooBig || misaligned || outOfRange;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg   <= '0;
      wrReg    <= 1'b0;
      lanesReg <= '0;
    end else if (stb.capture) begin
      idxReg   <= busAddr[OFF_W +: IDX_W];
      wrReg    <= busWrite;
      lanesReg <= lanes;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.beatDone && wrReg)
      for (int b = 0; b < BYTES; b++)
        if (lanesReg[b]) mem[idxReg][8*b +: 8] <= busWdata[8*b +: 8];
  end

  assign busRdata = mem[idxReg];

  // R5: a completing write always touches at least one lane
  p_lanes_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.beatDone && wrReg |-> lanesReg != '0);

  // R7: nothing refused is ever captured
  p_no_bad_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> !addrBad);

endmodule

// File: rtl/bmem_slave.sv
module bmem_slave
  import bmem_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 64,
  parameter int WAIT_STATES = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busTrans,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [2:0]        busSize,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  output logic [1:0]        busResp
);

  strobe_t stb;
  logic    addrBad;

  bmem_ctrl #(.WAIT_STATES(WAIT_STATES)) ctrl_i (
    .clk(clk), .rstN(rstN), .busTrans(busTrans), .addrBad(addrBad),
    .busReady(busReady), .busResp(busResp), .stb(stb)
  );

  bmem_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr), .busWrite(busWrite),
    .busSize(busSize), .busWdata(busWdata), .addrBad(addrBad), .busRdata(busRdata)
  );

endmodule

// File: tb/bmem_slave_tb_top.sv
module bmem_slave_tb_top;

  localparam logic [1:0] IDLE = 2'b00, BUSY = 2'b01, NSEQ = 2'b10, SEQ = 2'b11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busTrans = IDLE;
  logic [31:0] busAddr = '0;
  logic        busWrite = 1'b0;
  logic [2:0]  busSize = 3'd2;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, wsRdata;
  logic        busReady, wsReady;
  logic [1:0]  busResp, wsResp;

  int nChecks = 0, nFails = 0;
  logic badRespSeen = 1'b0;
  logic finished = 1'b0;
  logic        sRdy, sWsRdy;
  logic [1:0]  sRsp, sWsRsp;
  logic [31:0] sRd, sWsRd;

  always #5 clk = ~clk;

  bmem_slave dut_i (
    .clk(clk), .rstN(rstN), .busTrans(busTrans), .busAddr(busAddr),
    .busWrite(busWrite), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busReady(busReady), .busResp(busResp)
  );

  bmem_slave #(.WAIT_STATES(2)) dutWs_i (
    .clk(clk), .rstN(rstN), .busTrans(busTrans), .busAddr(busAddr),
    .busWrite(busWrite), .busSize(busSize), .busWdata(busWdata),
    .busRdata(wsRdata), .busReady(wsReady), .busResp(wsResp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one address phase (plus data for the previous one), then sample
  task automatic drive(input logic [1:0] tr, input logic [31:0] a, input logic w,
                       input logic [2:0] sz, input logic [31:0] wd);
    @(negedge clk);
    busTrans = tr; busAddr = a; busWrite = w; busSize = sz; busWdata = wd;
    #4;
    sRdy = busReady; sRsp = busResp; sRd = busRdata;
    sWsRdy = wsReady; sWsRsp = wsResp; sWsRd = wsRdata;
    if (busResp[1] || wsResp[1]) badRespSeen = 1'b1;
  endtask

  task automatic tReset;
    #4;
    check("R1 ready in reset", {31'd0, busReady}, 32'd1);
    check("R1 resp in reset", {30'd0, busResp}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    #4;
    check("R1 ready after reset", {31'd0, busReady}, 32'd1);
    check("R1 resp after reset", {30'd0, busResp}, 32'd0);
  endtask

  task automatic tWriteRead;
    drive(NSEQ, 32'h0, 1'b1, 3'd2, 32'h0);
    drive(NSEQ, 32'h0, 1'b0, 3'd2, 32'h12345678);
    check("R3 write completes at once", {31'd0, sRdy}, 32'd1);
    check("R4 write resp okay", {30'd0, sRsp}, 32'd0);
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'h0);
    check("R4 read after write", sRd, 32'h12345678);
  endtask

  task automatic tBurst;
    drive(NSEQ, 32'h20, 1'b1, 3'd2, 32'h0);
    for (int i = 1; i < 4; i++) begin
      drive(SEQ, 32'h20 + 32'(4 * i), 1'b1, 3'd2, 32'hA0B0C000 + 32'(i - 1));
      check("R3 back-to-back write ready", {31'd0, sRdy}, 32'd1);
    end
    drive(NSEQ, 32'h20, 1'b0, 3'd2, 32'hA0B0C003);
    check("R3 last burst write ready", {31'd0, sRdy}, 32'd1);
    for (int i = 1; i < 4; i++) begin
      drive(SEQ, 32'h20 + 32'(4 * i), 1'b0, 3'd2, 32'h0);
      check("R4 burst read data", sRd, 32'hA0B0C000 + 32'(i - 1));
    end
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'h0);
    check("R4 burst read last", sRd, 32'hA0B0C003);
  endtask

  task automatic tLanes;
    drive(NSEQ, 32'h8, 1'b1, 3'd2, 32'h0);
    drive(NSEQ, 32'h9, 1'b1, 3'd0, 32'h11223344);
    drive(NSEQ, 32'hA, 1'b1, 3'd1, 32'h0000AA00);
    drive(NSEQ, 32'h8, 1'b0, 3'd2, 32'hBEEF0000);
    drive(NSEQ, 32'h9, 1'b0, 3'd0, 32'h0);
    check("R5 byte and halfword lanes", sRd, 32'hBEEFAA44);
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'h0);
    check("R5 byte read returns full word", sRd, 32'hBEEFAA44);
  endtask

  task automatic tIdleBusy;
    drive(BUSY, 32'h0, 1'b1, 3'd2, 32'h0);
    drive(IDLE, 32'h0, 1'b1, 3'd2, 32'hDEADDEAD);
    check("R2 busy zero-wait", {31'd0, sRdy}, 32'd1);
    check("R2 busy okay", {30'd0, sRsp}, 32'd0);
    drive(NSEQ, 32'h0, 1'b0, 3'd2, 32'hFFFFFFFF);
    check("R2 idle zero-wait okay", {29'd0, sRdy, sRsp}, 32'd4);
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'h0);
    check("R2 idle/busy left memory alone", sRd, 32'h12345678);
  endtask

  task automatic tRange;
    drive(NSEQ, 32'hFC, 1'b1, 3'd2, 32'h0);
    drive(NSEQ, 32'h100, 1'b0, 3'd2, 32'h0F0F0F0F);
    check("R6 last word accepted", {29'd0, sRdy, sRsp}, 32'd4);
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'h0);
    check("R6 first error cycle", {29'd0, sRdy, sRsp}, 32'd1);
    drive(NSEQ, 32'hFC, 1'b0, 3'd2, 32'h0);
    check("R6 second error cycle", {29'd0, sRdy, sRsp}, 32'd5);
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'h0);
    check("R6 last word read", sRd, 32'h0F0F0F0F);
  endtask

  task automatic tMisalign;
    drive(NSEQ, 32'h10, 1'b1, 3'd2, 32'h0);
    drive(NSEQ, 32'h12, 1'b1, 3'd2, 32'hCAFEF00D);
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'hFFFFFFFF);
    check("R7 misaligned word error first", {29'd0, sRdy, sRsp}, 32'd1);
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'hFFFFFFFF);
    check("R7 misaligned word error second", {29'd0, sRdy, sRsp}, 32'd5);
    drive(NSEQ, 32'h11, 1'b1, 3'd1, 32'h0);
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'hFFFFFFFF);
    check("R7 odd halfword error", {29'd0, sRdy, sRsp}, 32'd1);
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'hFFFFFFFF);
    drive(NSEQ, 32'h10, 1'b1, 3'd3, 32'h0);
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'hFFFFFFFF);
    check("R7 oversize error", {29'd0, sRdy, sRsp}, 32'd1);
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'hFFFFFFFF);
    drive(NSEQ, 32'h10, 1'b0, 3'd2, 32'h0);
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'h0);
    check("R7 memory not written", sRd, 32'hCAFEF00D);
  endtask

  task automatic tWaitStates;
    for (int i = 0; i < 4; i++) drive(IDLE, 32'h0, 1'b0, 3'd2, 32'h0);
    drive(NSEQ, 32'h30, 1'b1, 3'd2, 32'h0);
    check("R8 ready before access", {31'd0, sWsRdy}, 32'd1);
    drive(NSEQ, 32'h30, 1'b0, 3'd2, 32'h5A5AA5A5);
    check("R8 wait cycle 1", {31'd0, sWsRdy}, 32'd0);
    drive(NSEQ, 32'h30, 1'b0, 3'd2, 32'h5A5AA5A5);
    check("R8 wait cycle 2", {31'd0, sWsRdy}, 32'd0);
    drive(NSEQ, 32'h30, 1'b0, 3'd2, 32'h5A5AA5A5);
    check("R8 write completes", {29'd0, sWsRdy, sWsRsp}, 32'd4);
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'h0);
    check("R8 read wait 1", {31'd0, sWsRdy}, 32'd0);
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'h0);
    check("R8 read wait 2", {31'd0, sWsRdy}, 32'd0);
    drive(NSEQ, 32'h400, 1'b0, 3'd2, 32'h0);
    check("R8 read completes", {31'd0, sWsRdy}, 32'd1);
    check("R4 read with waits", sWsRd, 32'h5A5AA5A5);
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'h0);
    check("R6 error with waits first", {29'd0, sWsRdy, sWsRsp}, 32'd1);
    drive(IDLE, 32'h0, 1'b0, 3'd2, 32'h0);
    check("R6 error with waits second", {29'd0, sWsRdy, sWsRsp}, 32'd5);
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    tReset;
    tWriteRead;
    tBurst;
    tLanes;
    tIdleBusy;
    tRange;
    tMisalign;
    tWaitStates;
    check("R9 response only okay or error", {31'd0, badRespSeen}, 32'd0);
    finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish;
  end

endmodule